// File: doc/BRIEF.md
# SD Host Command and Status Controller

This block sits between a processor's register bus and the serial engine of an SD host. Software programs an argument word, optionally a block length and a block count, and then writes a command word. Writing the command word is what launches the command. The block decodes that word into the fields the serial engine needs, pulses a command-valid strobe, and waits for the engine to report a response or a response error. A programmable cycle limit bounds that wait. A good response is stored in four 32-bit response words. Data commands then stay active until the engine reports that the data phase has finished or has timed out.

Events are collected in two status words. Sticky flags stay set until software writes zeros over them. Live bits mirror input levels and the busy state. Each status word has a mask word and its own interrupt line. The CRC, the serial shifting and the card model all sit in the serial engine, outside this block.

Top module: `sdc_cmd_ctrl`

## Requirements
- R1: After reset, both status words read 0 when all live inputs are low. Both mask words read 0x0000FFFF (every source masked). Every response word reads 0. The timeout register reads its reset parameter. Both interrupt lines are low.
- R2: A write to the command register (address 0) while the block is idle starts a command. Busy (status-2 bit 14) reads 1 from the next cycle. For exactly one cycle, `cmd_valid` is high and the card-side fields carry the decoded word: index = bits 5:0, app = bit 6, response type = bits 10:8, data = bit 11, read = bit 12, multi = bit 13, and auto-stop = NOT bit 14. The argument and the block length/count registers (addresses 1, 10, 11) drive their outputs.
- R3: On a good response (`rsp_err` = 0) to a short-response command, response word 0 (address 2) takes `rsp_payload[31:0]`, words 1 to 3 read 0, and status-1 bit 0 is set. A `rsp_valid` pulse while no command waits for a response changes no register.
- R4: For response type 6, the 120-bit payload (frame bits 127:8) is stored in staggered form. Word 0 holds frame bits 39:8, word 1 holds 71:40, word 2 holds 103:72, and word 3 holds 127:104 zero-extended.
- R5: Response type 3 (no response) finishes on the cycle after issue. Busy clears and status-1 bit 0 is set, with no response input needed.
- R6: A command-register write while busy is ignored: no `cmd_valid` pulse and no change to the card-side fields. It sets the illegal-access flag, status-2 bit 15.
- R7: A command word whose response type is 0, 1 or 2, or which has bit 7 or bit 15 set, is not issued and sets status-2 bit 15.
- R8: If the timeout register (address 12) holds T > 0 and no response arrives on the T clock edges after the issue edge, status-2 bit 6 is set and busy clears on the T-th edge.
- R9: A response with a non-zero `rsp_err` {end-bit, CRC, index} sets status-2 bits {2,1,0} to match. It ends the command and sets neither status-1 bit 0 nor any response word.
- R10: A data command stays busy after its response until `dat_done`, which sets status-1 bit 2, or until `dat_timeout`, which sets status-2 bit 3.
- R11: Writing a status word ANDs its sticky flags with the written value, so zeros clear and ones keep. Live bits are not affected. Sticky bits are status-1 {0,2,3,4} and status-2 {0..6,15}.
- R12: Status-1 bit 5 follows `card_detect`. A rising edge of `card_detect` sets bit 4, and a falling edge sets bit 3.
- R13: Status-2 bits 7, 8 and 9 follow `dat0_level`, `rbuf_ready` and `wbuf_ready`. `buf_err[0]` sets bit 4 and `buf_err[1]` sets bit 5.
- R14: Each interrupt line is high when any sticky flag of its status word is set and its mask bit (address 8 or 9) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| cmd_valid | output | 1 | One-cycle command launch strobe |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Argument latched at issue |
| cmd_rsp_type | output | 3 | Response type code |
| cmd_app | output | 1 | Application-specific command |
| cmd_has_data | output | 1 | Command has a data phase |
| cmd_read | output | 1 | Data direction is card to host |
| cmd_multi | output | 1 | Multi-block transfer |
| cmd_auto_stop | output | 1 | Engine issues the stop command itself |
| blk_size | output | BLK_W | Block length register |
| blk_count | output | CNT_W | Block count register |
| rsp_valid | input | 1 | Response received |
| rsp_err | input | 3 | {end-bit, CRC, index} errors with rsp_valid |
| rsp_payload | input | 120 | Response frame bits 127:8 |
| dat_done | input | 1 | Data phase finished |
| dat_timeout | input | 1 | Data phase timed out |
| buf_err | input | 2 | {illegal read, illegal write} buffer access |
| dat0_level | input | 1 | DAT0 line level |
| rbuf_ready | input | 1 | Read buffer ready |
| wbuf_ready | input | 1 | Write buffer ready |
| card_detect | input | 1 | Card-detect level |
| irq_status1 | output | 1 | Interrupt from status word 1 |
| irq_status2 | output | 1 | Interrupt from status word 2 |

## Verification
The bench builds the block with an 8-bit timeout register whose reset value is 12. This keeps the response window longer than any scripted handshake, so the busy-write and data-phase sequences never time out by accident. Software then reprograms the limit to 5, which makes the exact edge where the response timeout fires (R8) cheap to observe. A 10-bit block length and a 16-bit block count are enough to show 512-byte blocks on the outputs.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    // Register map (word addresses on the 4-bit register bus)
    typedef enum logic [3:0] {
        A_CMD    = 4'd0,
        A_ARG    = 4'd1,
        A_RSP0   = 4'd2,
        A_RSP1   = 4'd3,
        A_RSP2   = 4'd4,
        A_RSP3   = 4'd5,
        A_STAT1  = 4'd6,
        A_STAT2  = 4'd7,
        A_MASK1  = 4'd8,
        A_MASK2  = 4'd9,
        A_BLKSZ  = 4'd10,
        A_BLKCNT = 4'd11,
        A_TMO    = 4'd12
    } reg_addr_e;

    // Response type codes carried in command word bits 10:8
    localparam logic [2:0] RSP_NONE = 3'd3;
    localparam logic [2:0] RSP_R2   = 3'd6;

    // Status word 1 bit positions
    localparam int S1_RSP = 0;
    localparam int S1_CMP = 2;
    localparam int S1_REM = 3;
    localparam int S1_INS = 4;
    localparam int S1_CD  = 5;

    // Status word 2 bit positions
    localparam int S2_IDX  = 0;
    localparam int S2_DTO  = 3;
    localparam int S2_ILW  = 4;
    localparam int S2_ILR  = 5;
    localparam int S2_RTO  = 6;
    localparam int S2_DAT0 = 7;
    localparam int S2_RBUF = 8;
    localparam int S2_WBUF = 9;
    localparam int S2_BUSY = 14;
    localparam int S2_ILA  = 15;

    localparam logic [15:0] S1_STICKY = 16'h001D;
    localparam logic [15:0] S2_STICKY = 16'h807F;

    typedef struct packed {
        logic       nostop;
        logic       multi;
        logic       read;
        logic       data;
        logic       app;
        logic [2:0] rsp;
        logic [5:0] index;
    } cmd_t;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA} ctl_state_e;
endpackage

// File: rtl/sdc_cmd_decode.sv
// Command word decoder.
// Splits a 16-bit command word into its fields and judges whether it may be issued.
// Assumes: only response codes 3..7 are legal; bits 7 and 15 are reserved and must be 0.
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic [15:0] word,
    output cmd_t        cmd,
    output logic        legal,
    output logic        long_rsp,
    output logic        no_rsp
);
    // Field extraction and legality check
    always_comb begin
        cmd.index  = word[5:0];
        cmd.app    = word[6];
        cmd.rsp    = word[10:8];
        cmd.data   = word[11];
        cmd.read   = word[12];
        cmd.multi  = word[13];
        cmd.nostop = word[14];
        legal      = (word[10:8] >= RSP_NONE) && !word[7] && !word[15];
        long_rsp   = (word[10:8] == RSP_R2);
        no_rsp     = (word[10:8] == RSP_NONE);
    end
endmodule

// File: rtl/sdc_rsp_store.sv
// Response word storage.
// Holds the response payload in staggered 32-bit words; the last word is zero-extended.
// Assumes: the payload is frame bits 127:8; a short response uses only payload[31:0].
module sdc_rsp_store #(
    parameter int NWORDS = 4,
    parameter int PAY_W  = 120
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic                  long_rsp,
    input  logic [PAY_W-1:0]      payload,
    output logic [NWORDS*32-1:0]  words
);
    genvar k;
    generate
        for (k = 0; k < NWORDS; k++) begin : g_word
            localparam int LO = 32 * k;
            localparam int W  = ((PAY_W - LO) < 32) ? (PAY_W - LO) : 32;
            logic [31:0] word_q;
            // Load one word on capture; only word 0 is kept for short responses
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (capture)
                    word_q <= (long_rsp || k == 0) ? 32'(payload[LO +: W]) : 32'd0;
            end
            assign words[LO +: 32] = word_q;
        end
    endgenerate
endmodule

// File: rtl/sdc_status.sv
// Status, mask and interrupt logic.
// Keeps the sticky flags of both status words; writes AND the flags (zeros clear),
// a set in the same cycle wins. Live bits are merged into the read view.
// Assumes: set and live inputs are synchronous to clk.
module sdc_status
    import sdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] set1,
    input  logic [15:0] set2,
    input  logic [15:0] live1,
    input  logic [15:0] live2,
    input  logic        wr_s1,
    input  logic        wr_s2,
    input  logic        wr_m1,
    input  logic        wr_m2,
    input  logic [15:0] wdata,
    output logic [15:0] stat1,
    output logic [15:0] stat2,
    output logic [15:0] mask1,
    output logic [15:0] mask2,
    output logic        irq1,
    output logic        irq2
);
    logic [15:0] sticky1, sticky2;

    // Sticky flag update: write-AND clear, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky1 <= '0;
            sticky2 <= '0;
        end else begin
            sticky1 <= ((wr_s1 ? (sticky1 & wdata) : sticky1) | set1) & S1_STICKY;
            sticky2 <= ((wr_s2 ? (sticky2 & wdata) : sticky2) | set2) & S2_STICKY;
        end
    end

    // Mask registers, all sources masked after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask1 <= '1;
            mask2 <= '1;
        end else begin
            if (wr_m1) mask1 <= wdata;
            if (wr_m2) mask2 <= wdata;
        end
    end

    // Read view and interrupt lines
    always_comb begin
        stat1 = sticky1 | (live1 & ~S1_STICKY);
        stat2 = sticky2 | (live2 & ~S2_STICKY);
        irq1  = |(sticky1 & ~mask1);
        irq2  = |(sticky2 & ~mask2);
    end

    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s1 && wdata == 16'h0 && set1 == 16'h0) |=> ((stat1 & S1_STICKY) == 16'h0));
endmodule

// File: rtl/sdc_cmd_ctrl.sv
// SD host command and status controller (top).
// Decodes register writes, launches commands to the serial engine, waits for the
// response with a programmable cycle limit, follows the data phase, and feeds the
// status block. Assumes: all inputs are synchronous to clk; card_detect is debounced.
module sdc_cmd_ctrl
    import sdc_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int TMO_RESET = 4096,
    parameter int BLK_W     = 12,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [3:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic               cmd_valid,
    output logic [5:0]         cmd_index,
    output logic [31:0]        cmd_arg,
    output logic [2:0]         cmd_rsp_type,
    output logic               cmd_app,
    output logic               cmd_has_data,
    output logic               cmd_read,
    output logic               cmd_multi,
    output logic               cmd_auto_stop,
    output logic [BLK_W-1:0]   blk_size,
    output logic [CNT_W-1:0]   blk_count,
    input  logic               rsp_valid,
    input  logic [2:0]         rsp_err,
    input  logic [119:0]       rsp_payload,
    input  logic               dat_done,
    input  logic               dat_timeout,
    input  logic [1:0]         buf_err,
    input  logic               dat0_level,
    input  logic               rbuf_ready,
    input  logic               wbuf_ready,
    input  logic               card_detect,
    output logic               irq_status1,
    output logic               irq_status2
);
    localparam int NWORDS = 4;
    localparam int PAY_W  = 120;

    ctl_state_e       state;
    cmd_t             dec, cmd_q;
    logic             dec_legal, dec_long, dec_none;
    logic [15:0]      cmd_word_q;
    logic [31:0]      arg_q;
    logic [TMO_W-1:0] tmo_q, cnt;
    logic             cd_q;
    logic             wr_cmd, issue, q_none, tmo_hit, rsp_ok, rsp_bad, waiting;
    logic [15:0]      set1, set2, live1, live2, stat1, stat2, mask1, mask2;
    logic [NWORDS*32-1:0] rsp_words;

    sdc_cmd_decode u_dec (
        .word     (wr_data[15:0]),
        .cmd      (dec),
        .legal    (dec_legal),
        .long_rsp (dec_long),
        .no_rsp   (dec_none)
    );

    // Launch, response and timeout conditions
    always_comb begin
        wr_cmd  = wr_en && (wr_addr == A_CMD);
        issue   = wr_cmd && (state == ST_IDLE) && dec_legal;
        q_none  = (cmd_q.rsp == RSP_NONE);
        waiting = (state == ST_WAIT) && !q_none;
        rsp_ok  = waiting && rsp_valid && (rsp_err == 3'b000);
        rsp_bad = waiting && rsp_valid && (rsp_err != 3'b000);
        tmo_hit = waiting && !rsp_valid && (tmo_q != '0) && (cnt == tmo_q - 1'b1);
    end

    // Command sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cmd_valid  <= 1'b0;
            cmd_q      <= '0;
            cmd_word_q <= '0;
            cmd_arg    <= '0;
            cnt        <= '0;
        end else begin
            cmd_valid <= 1'b0;
            case (state)
                ST_IDLE: if (issue) begin
                    state      <= ST_WAIT;
                    cmd_valid  <= 1'b1;
                    cmd_q      <= dec;
                    cmd_word_q <= wr_data[15:0];
                    cmd_arg    <= arg_q;
                    cnt        <= '0;
                end
                ST_WAIT: begin
                    if (q_none)
                        state <= cmd_q.data ? ST_DATA : ST_IDLE;
                    else if (rsp_valid)
                        state <= (rsp_ok && cmd_q.data) ? ST_DATA : ST_IDLE;
                    else if (tmo_hit)
                        state <= ST_IDLE;
                    else
                        cnt <= cnt + 1'b1;
                end
                ST_DATA: if (dat_done || dat_timeout) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Plain configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q     <= '0;
            blk_size  <= '0;
            blk_count <= '0;
            tmo_q     <= TMO_W'(TMO_RESET);
            cd_q      <= 1'b0;
        end else begin
            cd_q <= card_detect;
            if (wr_en && wr_addr == A_ARG)    arg_q     <= wr_data;
            if (wr_en && wr_addr == A_BLKSZ)  blk_size  <= wr_data[BLK_W-1:0];
            if (wr_en && wr_addr == A_BLKCNT) blk_count <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == A_TMO)    tmo_q     <= wr_data[TMO_W-1:0];
        end
    end

    // Status event and live-bit assembly
    always_comb begin
        set1 = '0;
        set2 = '0;
        set1[S1_RSP] = rsp_ok || ((state == ST_WAIT) && q_none);
        set1[S1_CMP] = (state == ST_DATA) && dat_done;
        set1[S1_REM] = cd_q && !card_detect;
        set1[S1_INS] = card_detect && !cd_q;
        set2[S2_IDX +: 3] = rsp_bad ? rsp_err : 3'b000;
        set2[S2_DTO] = (state == ST_DATA) && dat_timeout && !dat_done;
        set2[S2_ILW] = buf_err[0];
        set2[S2_ILR] = buf_err[1];
        set2[S2_RTO] = tmo_hit;
        set2[S2_ILA] = wr_cmd && ((state != ST_IDLE) || !dec_legal);
        live1 = '0;
        live2 = '0;
        live1[S1_CD]   = card_detect;
        live2[S2_DAT0] = dat0_level;
        live2[S2_RBUF] = rbuf_ready;
        live2[S2_WBUF] = wbuf_ready;
        live2[S2_BUSY] = (state != ST_IDLE);
    end

    sdc_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set1  (set1),
        .set2  (set2),
        .live1 (live1),
        .live2 (live2),
        .wr_s1 (wr_en && wr_addr == A_STAT1),
        .wr_s2 (wr_en && wr_addr == A_STAT2),
        .wr_m1 (wr_en && wr_addr == A_MASK1),
        .wr_m2 (wr_en && wr_addr == A_MASK2),
        .wdata (wr_data[15:0]),
        .stat1 (stat1),
        .stat2 (stat2),
        .mask1 (mask1),
        .mask2 (mask2),
        .irq1  (irq_status1),
        .irq2  (irq_status2)
    );

    sdc_rsp_store #(.NWORDS(NWORDS), .PAY_W(PAY_W)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rsp_ok),
        .long_rsp (cmd_q.rsp == RSP_R2),
        .payload  (rsp_payload),
        .words    (rsp_words)
    );

    // Card-side field outputs
    always_comb begin
        cmd_index     = cmd_q.index;
        cmd_rsp_type  = cmd_q.rsp;
        cmd_app       = cmd_q.app;
        cmd_has_data  = cmd_q.data;
        cmd_read      = cmd_q.read;
        cmd_multi     = cmd_q.multi;
        cmd_auto_stop = !cmd_q.nostop;
    end

    // Register read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMD:    rd_data[15:0] = cmd_word_q;
            A_ARG:    rd_data = arg_q;
            A_RSP0:   rd_data = rsp_words[31:0];
            A_RSP1:   rd_data = rsp_words[63:32];
            A_RSP2:   rd_data = rsp_words[95:64];
            A_RSP3:   rd_data = rsp_words[127:96];
            A_STAT1:  rd_data[15:0] = stat1;
            A_STAT2:  rd_data[15:0] = stat2;
            A_MASK1:  rd_data[15:0] = mask1;
            A_MASK2:  rd_data[15:0] = mask2;
            A_BLKSZ:  rd_data[BLK_W-1:0] = blk_size;
            A_BLKCNT: rd_data[CNT_W-1:0] = blk_count;
            A_TMO:    rd_data[TMO_W-1:0] = tmo_q;
            default:  rd_data = '0;
        endcase
    end

    // R6
    ila_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && stat2[S2_BUSY]) |=> stat2[S2_ILA]);
    // R2
    cmd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R2
    cmd_valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> stat2[S2_BUSY]);
    // R8
    busy_end_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat2[S2_BUSY]) |-> (stat1[S1_RSP] || stat1[S1_CMP] || (stat2[6:0] != 7'h0)));
    // R3
    rsp_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat2[S2_BUSY] |=> $stable(rsp_words));
endmodule

// File: tb/sdc_cmd_ctrl_bench.sv
module sdc_cmd_ctrl_bench;
    import sdc_pkg::*;

    localparam int TMO_W = 8;
    localparam int BLK_W = 10;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic cmd_valid, cmd_app, cmd_has_data, cmd_read, cmd_multi, cmd_auto_stop;
    logic [5:0] cmd_index;
    logic [31:0] cmd_arg;
    logic [2:0] cmd_rsp_type;
    logic [BLK_W-1:0] blk_size;
    logic [CNT_W-1:0] blk_count;
    logic rsp_valid = 1'b0;
    logic [2:0] rsp_err = '0;
    logic [119:0] rsp_payload = '0;
    logic dat_done = 1'b0, dat_timeout = 1'b0;
    logic [1:0] buf_err = '0;
    logic dat0_level = 1'b0, rbuf_ready = 1'b0, wbuf_ready = 1'b0, card_detect = 1'b0;
    logic irq_status1, irq_status2;

    always #10 clk = ~clk;

    sdc_cmd_ctrl #(.TMO_W(TMO_W), .TMO_RESET(12), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_sdc_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_rsp_type(cmd_rsp_type), .cmd_app(cmd_app),
        .cmd_has_data(cmd_has_data), .cmd_read(cmd_read), .cmd_multi(cmd_multi),
        .cmd_auto_stop(cmd_auto_stop), .blk_size(blk_size), .blk_count(blk_count),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_payload(rsp_payload),
        .dat_done(dat_done), .dat_timeout(dat_timeout), .buf_err(buf_err),
        .dat0_level(dat0_level), .rbuf_ready(rbuf_ready), .wbuf_ready(wbuf_ready),
        .card_detect(card_detect), .irq_status1(irq_status1), .irq_status2(irq_status2)
    );

    typedef struct {
        logic [3:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int pushed = 0, mon_done = 0;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected register values and compares them to the read port
    initial begin
        forever begin
            sb_item_t it;
            wait (pushed > mon_done);
            it = sb_q.pop_front();
            rd_addr = it.addr;
            #1;
            chk(it.tag, rd_data, it.exp);
            mon_done++;
        end
    end

    // Driver side: push an expectation and wait until the monitor has consumed it
    task automatic expect_reg(input logic [3:0] a, input logic [31:0] v, input string tag);
        sb_item_t it;
        it.addr = a;
        it.exp  = v;
        it.tag  = tag;
        sb_q.push_back(it);
        pushed++;
        wait (mon_done == pushed);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic respond(input logic [119:0] p, input logic [2:0] e);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_payload = p; rsp_err = e;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = '0;
    endtask

    task automatic clear_status;
        reg_write(A_STAT1, 32'h0);
        reg_write(A_STAT2, 32'h0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [119:0] pay;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_reg(A_STAT1, 32'h0, "R1 stat1");
        expect_reg(A_STAT2, 32'h0, "R1 stat2");
        expect_reg(A_MASK1, 32'h0000FFFF, "R1 mask1");
        expect_reg(A_MASK2, 32'h0000FFFF, "R1 mask2");
        expect_reg(A_RSP0, 32'h0, "R1 rsp0");
        expect_reg(A_TMO, 32'd12, "R1 timeout");
        chk("R1 irq", {30'h0, irq_status1, irq_status2}, 32'h0);

        // R2 data read command: index 18, R1, data, read, multi
        reg_write(A_BLKSZ, 32'd512);
        reg_write(A_BLKCNT, 32'd3);
        reg_write(A_ARG, 32'hA5A51234);
        reg_write(A_CMD, 32'h00003C12);
        chk("R2 cmd_valid", {31'h0, cmd_valid}, 32'h1);
        chk("R2 index", {26'h0, cmd_index}, 32'd18);
        chk("R2 arg", cmd_arg, 32'hA5A51234);
        chk("R2 flags", {25'h0, cmd_rsp_type, cmd_app, cmd_has_data, cmd_read, cmd_multi},
            {25'h0, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1});
        chk("R2 auto stop", {31'h0, cmd_auto_stop}, 32'h1);
        chk("R2 blk", {6'h0, blk_size, blk_count}, {6'h0, 10'd512, 16'd3});
        expect_reg(A_STAT2, 32'h4000, "R2 busy");
        @(negedge clk);
        chk("R2 pulse", {31'h0, cmd_valid}, 32'h0);

        // R6 write while busy is ignored
        reg_write(A_ARG, 32'h0BADF00D);
        reg_write(A_CMD, 32'h00000411);
        chk("R6 no pulse", {31'h0, cmd_valid}, 32'h0);
        chk("R6 index kept", {26'h0, cmd_index}, 32'd18);
        chk("R6 arg kept", cmd_arg, 32'hA5A51234);
        expect_reg(A_STAT2, 32'hC000, "R6 illegal access");
        reg_write(A_STAT2, 32'h0);
        expect_reg(A_STAT2, 32'h4000, "R11 busy is live");

        // R10 data phase after the response
        pay = '0; pay[31:0] = 32'h00000900;
        respond(pay, 3'b000);
        expect_reg(A_RSP0, 32'h00000900, "R10 rsp0");
        expect_reg(A_STAT1, 32'h1, "R10 rsp flag");
        expect_reg(A_STAT2, 32'h4000, "R10 busy in data");
        @(negedge clk); dat_done = 1'b1;
        @(negedge clk); dat_done = 1'b0;
        expect_reg(A_STAT1, 32'h5, "R10 complete");
        expect_reg(A_STAT2, 32'h0, "R10 idle");

        // R11 write-AND clear
        reg_write(A_STAT1, 32'h0000FFFB);
        expect_reg(A_STAT1, 32'h1, "R11 partial clear");
        reg_write(A_STAT1, 32'h0);
        expect_reg(A_STAT1, 32'h0, "R11 full clear");

        // R4 long response
        clear_status();
        reg_write(A_CMD, 32'h00000602);
        respond({24'h4B5A69, 32'h0F1E2D3C, 32'h89ABCDEF, 32'h01234567}, 3'b000);
        expect_reg(A_RSP0, 32'h01234567, "R4 word0");
        expect_reg(A_RSP1, 32'h89ABCDEF, "R4 word1");
        expect_reg(A_RSP2, 32'h0F1E2D3C, "R4 word2");
        expect_reg(A_RSP3, 32'h004B5A69, "R4 word3");
        expect_reg(A_STAT2, 32'h0, "R4 idle");

        // R3 short response zeroes upper words; stray response ignored
        clear_status();
        reg_write(A_CMD, 32'h0000040D);
        respond({88'hFFFF_FFFF_FFFF_FFFF_FFFF_FF, 32'hCAFEF00D}, 3'b000);
        expect_reg(A_RSP0, 32'hCAFEF00D, "R3 word0");
        expect_reg(A_RSP1, 32'h0, "R3 word1");
        expect_reg(A_RSP3, 32'h0, "R3 word3");
        expect_reg(A_STAT1, 32'h1, "R3 rsp flag");
        reg_write(A_STAT1, 32'h0);
        respond({88'h0, 32'h12345678}, 3'b000);
        expect_reg(A_RSP0, 32'hCAFEF00D, "R3 stray ignored");
        expect_reg(A_STAT1, 32'h0, "R3 stray no flag");

        // R5 no-response command
        clear_status();
        reg_write(A_CMD, 32'h00000300);
        expect_reg(A_STAT2, 32'h4000, "R5 busy one cycle");
        @(negedge clk);
        expect_reg(A_STAT2, 32'h0, "R5 done");
        expect_reg(A_STAT1, 32'h1, "R5 rsp flag");

        // R7 illegal words
        clear_status();
        reg_write(A_CMD, 32'h00000005);
        chk("R7 no pulse", {31'h0, cmd_valid}, 32'h0);
        expect_reg(A_STAT2, 32'h8000, "R7 bad type");
        reg_write(A_STAT2, 32'h0);
        reg_write(A_CMD, 32'h00000485);
        expect_reg(A_STAT2, 32'h8000, "R7 reserved bit");

        // R8 timeout with limit 5, R14 interrupt on status 2
        clear_status();
        reg_write(A_MASK2, 32'h0000FFBF);
        reg_write(A_TMO, 32'd5);
        reg_write(A_CMD, 32'h00000408);
        repeat (4) @(negedge clk);
        expect_reg(A_STAT2, 32'h4000, "R8 still busy");
        @(negedge clk);
        expect_reg(A_STAT2, 32'h0040, "R8 timeout");
        chk("R14 irq2 set", {31'h0, irq_status2}, 32'h1);
        reg_write(A_STAT2, 32'h0);
        chk("R14 irq2 clear", {31'h0, irq_status2}, 32'h0);

        // R9 response error
        reg_write(A_CMD, 32'h00000408);
        respond({88'h0, 32'h77777777}, 3'b010);
        expect_reg(A_STAT2, 32'h0002, "R9 crc error");
        expect_reg(A_STAT1, 32'h0, "R9 no rsp flag");
        expect_reg(A_RSP0, 32'hCAFEF00D, "R9 rsp kept");

        // R10 data timeout
        clear_status();
        reg_write(A_CMD, 32'h00000C11);
        respond(120'h0, 3'b000);
        @(negedge clk); dat_timeout = 1'b1;
        @(negedge clk); dat_timeout = 1'b0;
        expect_reg(A_STAT2, 32'h0008, "R10 data timeout");
        expect_reg(A_STAT1, 32'h1, "R10 no complete");

        // R12 card detect
        clear_status();
        @(negedge clk); card_detect = 1'b1;
        @(negedge clk);
        expect_reg(A_STAT1, 32'h30, "R12 insert");
        reg_write(A_STAT1, 32'h0);
        expect_reg(A_STAT1, 32'h20, "R12 level live");
        @(negedge clk); card_detect = 1'b0;
        @(negedge clk);
        expect_reg(A_STAT1, 32'h08, "R12 remove");

        // R13 live bits and buffer errors
        clear_status();
        @(negedge clk); dat0_level = 1'b1; rbuf_ready = 1'b1; buf_err = 2'b11;
        @(negedge clk); buf_err = 2'b00;
        expect_reg(A_STAT2, 32'h01B0, "R13 live and errors");
        reg_write(A_STAT2, 32'h0);
        expect_reg(A_STAT2, 32'h0180, "R13 live kept");
        dat0_level = 1'b0; rbuf_ready = 1'b0; wbuf_ready = 1'b1;
        #1;
        expect_reg(A_STAT2, 32'h0200, "R13 write ready");

        // R14 interrupt on status 1 with masking
        clear_status();
        reg_write(A_MASK1, 32'h0000FFFE);
        reg_write(A_CMD, 32'h00000300);
        @(negedge clk);
        chk("R14 irq1 set", {31'h0, irq_status1}, 32'h1);
        reg_write(A_MASK1, 32'h0000FFFF);
        chk("R14 irq1 masked", {31'h0, irq_status1}, 32'h0);
        expect_reg(A_STAT1, 32'h1, "R14 flag kept");

        summary();
    end
endmodule